// File: doc/BRIEF.md
# Barrier-Aware Packet Dispatch Controller

This block sits in front of one command queue and looks at the packet waiting at the queue's dispatch slot. On each wakeup it reads the packet header and takes one of several actions. Compute and vendor packets go downstream through a valid/ready handshake. A packet with its ordering flag set is held while earlier packets are still running. An AND-barrier packet polls a small set of dependency signals. An illegal packet type stops the queue for good.

Only one packet is handled per wakeup. Wakeups are spaced by a delay that software programs. The block counts dispatched packets that have not yet reported completion. From that count it sets and clears a queue-level hold flag, and the flag is visible on `blocked`. Signal reads go out on a request port as a slot mask and return one slot per response. A decrement of a packet's completion signal is reported as a one-cycle pulse.

Top module: `pkt_dispatch_ctrl`

## Requirements
- R1: Header bits [7:0] give the packet type. Type 2 (compute) is forwarded with `dsp_kind` 0, type 0 (vendor) with `dsp_kind` 1, and type 4 (agent) with `dsp_kind` 2. `dsp_valid` and `dsp_kind` stay steady until `dsp_ready`. `pkt_pop` pulses for one cycle in the cycle after the handshake.
- R2: Header bit 8 is the ordering flag. If a packet has this flag set while at least one dispatched packet is still incomplete, the packet is not forwarded and `blocked` goes to 1.
- R3: A compute packet with header bit 8 set is forwarded first. `blocked` then goes to 1, and later packets wait.
- R4: `blocked` returns to 0 when the last incomplete packet reports `cpl_done`. Any waiting packet then proceeds on a new wakeup.
- R5: With `dsp_ready` held at 1, successive forwarded packets pop exactly `wake_dly`+2 cycles apart.
- R6: On its first evaluation, an AND-barrier packet (type 3) issues one read request whose mask equals its connected-slot mask `pkt_dep_conn`.
- R7: Later evaluations of the same AND-barrier packet re-read only the slots that last returned nonzero. The packet retires once every connected slot has returned zero. A packet with no connected slots retires on its first evaluation.
- R8: While any signal read is outstanding, a wakeup issues no new request and does not retire the packet.
- R9: A retiring AND-barrier packet pops. It pulses `sig_dec_valid` in the same cycle if `pkt_cpl_conn` is 1. Its stored signal results are cleared, so the next AND-barrier packet starts with a full read.
- R10: An agent packet pulses `sig_dec_valid` in the same cycle as its pop.
- R11: Types 1 and 5, and any code above 5, set `err`. `err` never clears, and no further packet is forwarded or popped.
- R12: A handshake and a `cpl_done` in the same cycle leave the incomplete-packet count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_dly | input | DLY_W | Cycles between wakeups (0 acts as 1) |
| pkt_valid | input | 1 | A packet is present at the dispatch slot |
| pkt_hdr | input | 16 | Header of that packet |
| pkt_dep_conn | input | NSIG | Connected dependency slots of an AND-barrier packet |
| pkt_cpl_conn | input | 1 | AND-barrier packet has a completion signal |
| pkt_pop | output | 1 | Advance the dispatch slot |
| dsp_valid | output | 1 | Forward request downstream |
| dsp_kind | output | 2 | Forwarded packet class |
| dsp_ready | input | 1 | Downstream accepts |
| cpl_done | input | 1 | One forwarded packet finished |
| sig_rd_valid | output | 1 | Dependency read request |
| sig_rd_mask | output | NSIG | Slots to read |
| sig_rsp_valid | input | 1 | One read result |
| sig_rsp_slot | input | SLOT_W | Slot of the result |
| sig_rsp_nz | input | 1 | Result value is nonzero |
| sig_dec_valid | output | 1 | Decrement a completion signal |
| blocked | output | 1 | Queue hold flag |
| err | output | 1 | Sticky illegal-packet flag |

## Verification
The forward handshake of one packet and the completion of an earlier packet can land on the same clock edge. Together they decide the incomplete-packet count, and that count drives the hold flag. The bench holds a compute packet at `dsp_valid` with `dsp_ready` low. It then raises `dsp_ready` and `cpl_done` on the same edge, and follows with an ordered packet. The result is judged at the ports. The ordered packet must stay blocked, and must go out after exactly one more completion.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int HDR_W    = 16;
  localparam int TYPE_LSB = 0;
  localparam int TYPE_W   = 8;
  localparam int ORD_BIT  = 8;

  localparam logic [TYPE_W-1:0] PT_VENDOR  = 8'd0;
  localparam logic [TYPE_W-1:0] PT_INVALID = 8'd1;
  localparam logic [TYPE_W-1:0] PT_KERNEL  = 8'd2;
  localparam logic [TYPE_W-1:0] PT_AND     = 8'd3;
  localparam logic [TYPE_W-1:0] PT_AGENT   = 8'd4;
  localparam logic [TYPE_W-1:0] PT_OR      = 8'd5;

  typedef enum logic [1:0] {
    KIND_KERNEL = 2'd0,
    KIND_VENDOR = 2'd1,
    KIND_AGENT  = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DISP = 2'd2,
    ST_HALT = 2'd3
  } state_e;
endpackage

// File: rtl/pdc_wake_timer.sv
module pdc_wake_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [DLY_W-1:0] delay,
  output logic             fire
);
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] lim;

  assign lim  = (delay == '0) ? '0 : delay - 1'b1;
  assign fire = arm && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || !arm || fire) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pdc_outstanding.sv
module pdc_outstanding #(
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec_req,
  output logic [OUT_W-1:0] count,
  output logic             drain
);
  logic dec;

  assign dec   = dec_req && (count != '0);
  assign drain = dec && !inc && (count == OUT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (inc && !dec) count <= count + 1'b1;
    else if (dec && !inc) count <= count - 1'b1;
  end
endmodule

// File: rtl/pdc_sig_poll.sv
module pdc_sig_poll #(
  parameter int NSIG   = 5,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSIG-1:0]   conn,
  input  logic              issue,
  input  logic              clear,
  input  logic              rsp_valid,
  input  logic [SLOT_W-1:0] rsp_slot,
  input  logic              rsp_nz,
  output logic              busy,
  output logic [NSIG-1:0]   need_mask
);
  localparam int CNT_W = $clog2(NSIG + 1);

  logic [CNT_W-1:0] pending;
  logic             read_done;
  logic [NSIG-1:0]  val_nz;

  assign busy      = (pending != '0);
  assign need_mask = read_done ? (conn & val_nz) : conn;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pending   <= '0;
      read_done <= 1'b0;
    end else if (issue) begin
      pending   <= CNT_W'($countones(need_mask));
      read_done <= 1'b0;
    end else if (rsp_valid && busy) begin
      pending <= pending - 1'b1;
      if (pending == CNT_W'(1)) read_done <= 1'b1;
    end
  end

  for (genvar g = 0; g < NSIG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear)
        val_nz[g] <= 1'b0;
      else if (rsp_valid && busy && (rsp_slot == SLOT_W'(g)))
        val_nz[g] <= rsp_nz;
    end
  end
endmodule

// File: rtl/pkt_dispatch_ctrl.sv
module pkt_dispatch_ctrl
  import pdc_pkg::*;
#(
  parameter int NSIG   = 5,
  parameter int DLY_W  = 8,
  parameter int OUT_W  = 6,
  parameter int SLOT_W = (NSIG > 1) ? $clog2(NSIG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DLY_W-1:0]  wake_dly,
  input  logic              pkt_valid,
  input  logic [15:0]       pkt_hdr,
  input  logic [NSIG-1:0]   pkt_dep_conn,
  input  logic              pkt_cpl_conn,
  output logic              pkt_pop,
  output logic              dsp_valid,
  output logic [1:0]        dsp_kind,
  input  logic              dsp_ready,
  input  logic              cpl_done,
  output logic              sig_rd_valid,
  output logic [NSIG-1:0]   sig_rd_mask,
  input  logic              sig_rsp_valid,
  input  logic [SLOT_W-1:0] sig_rsp_slot,
  input  logic              sig_rsp_nz,
  output logic              sig_dec_valid,
  output logic              blocked,
  output logic              err
);
  state_e            st;
  logic              fire;
  logic              wake;
  logic [OUT_W-1:0]  out_cnt;
  logic              drain;
  logic              handshake;
  logic              poll_busy;
  logic [NSIG-1:0]   need_mask;
  logic [TYPE_W-1:0] ptype;
  logic              ord;
  logic              agent_q;
  logic              kord_q;

  logic do_block, do_fwd, do_issue, do_retire, do_fault, do_idle;

  assign ptype     = pkt_hdr[TYPE_LSB +: TYPE_W];
  assign ord       = pkt_hdr[ORD_BIT];
  assign wake      = (st == ST_WAIT) && fire;
  assign handshake = (st == ST_DISP) && dsp_ready;

  pdc_wake_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .arm(st == ST_WAIT), .delay(wake_dly), .fire(fire)
  );

  pdc_outstanding #(.OUT_W(OUT_W)) u_outst (
    .clk(clk), .rst(rst), .inc(handshake), .dec_req(cpl_done),
    .count(out_cnt), .drain(drain)
  );

  pdc_sig_poll #(.NSIG(NSIG), .SLOT_W(SLOT_W)) u_poll (
    .clk(clk), .rst(rst), .conn(pkt_dep_conn), .issue(do_issue),
    .clear(do_retire), .rsp_valid(sig_rsp_valid), .rsp_slot(sig_rsp_slot),
    .rsp_nz(sig_rsp_nz), .busy(poll_busy), .need_mask(need_mask)
  );

  // Decision taken at a wakeup, in priority order
  always_comb begin
    do_block  = 1'b0;
    do_fwd    = 1'b0;
    do_issue  = 1'b0;
    do_retire = 1'b0;
    do_fault  = 1'b0;
    do_idle   = 1'b0;
    if (wake) begin
      if (blocked || !pkt_valid) begin
        do_idle = 1'b1;
      end else if (poll_busy) begin
        do_idle = 1'b0;
      end else if (ord && (out_cnt != '0) && !drain) begin
        do_block = 1'b1;
      end else begin
        unique case (ptype)
          PT_KERNEL, PT_VENDOR, PT_AGENT: do_fwd = 1'b1;
          PT_AND: begin
            if (need_mask == '0) do_retire = 1'b1;
            else                 do_issue  = 1'b1;
          end
          default: do_fault = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      pkt_pop       <= 1'b0;
      dsp_valid     <= 1'b0;
      dsp_kind      <= KIND_KERNEL;
      sig_rd_valid  <= 1'b0;
      sig_rd_mask   <= '0;
      sig_dec_valid <= 1'b0;
      err           <= 1'b0;
      agent_q       <= 1'b0;
      kord_q        <= 1'b0;
    end else begin
      pkt_pop       <= 1'b0;
      sig_rd_valid  <= 1'b0;
      sig_dec_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (pkt_valid && !blocked) st <= ST_WAIT;
        ST_WAIT: begin
          if (do_idle) st <= ST_IDLE;
          if (do_fwd) begin
            st        <= ST_DISP;
            dsp_valid <= 1'b1;
            agent_q   <= (ptype == PT_AGENT);
            kord_q    <= (ptype == PT_KERNEL) && ord;
            dsp_kind  <= (ptype == PT_KERNEL) ? KIND_KERNEL :
                         (ptype == PT_VENDOR) ? KIND_VENDOR : KIND_AGENT;
          end
          if (do_issue) begin
            sig_rd_valid <= 1'b1;
            sig_rd_mask  <= need_mask;
          end
          if (do_retire) begin
            st            <= ST_IDLE;
            pkt_pop       <= 1'b1;
            sig_dec_valid <= pkt_cpl_conn;
          end
          if (do_fault) begin
            st  <= ST_HALT;
            err <= 1'b1;
          end
        end
        ST_DISP: if (dsp_ready) begin
          st            <= ST_IDLE;
          dsp_valid     <= 1'b0;
          pkt_pop       <= 1'b1;
          sig_dec_valid <= agent_q;
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  // Queue hold flag: setting wins over clearing
  always_ff @(posedge clk) begin
    if (rst)                             blocked <= 1'b0;
    else if (do_block || (handshake && kord_q)) blocked <= 1'b1;
    else if (drain)                      blocked <= 1'b0;
  end
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int NSIG = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            dsp_valid,
  input logic [1:0]      dsp_kind,
  input logic            dsp_ready,
  input logic            pkt_pop,
  input logic            sig_rd_valid,
  input logic [NSIG-1:0] sig_rd_mask,
  input logic [NSIG-1:0] pkt_dep_conn,
  input logic            sig_dec_valid,
  input logic            blocked,
  input logic            err
);
  AST_DSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_kind))); // R1

  AST_NO_FWD_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(dsp_valid) |-> !blocked); // R2

  AST_RD_SUBSET: assert property (@(posedge clk) disable iff (rst)
    sig_rd_valid |-> ((sig_rd_mask != '0) && ((sig_rd_mask & ~$past(pkt_dep_conn)) == '0))); // R6

  AST_RD_SPACED: assert property (@(posedge clk) disable iff (rst)
    sig_rd_valid |=> !sig_rd_valid); // R8

  AST_DEC_WITH_POP: assert property (@(posedge clk) disable iff (rst)
    sig_dec_valid |-> pkt_pop); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> (err && !dsp_valid && !pkt_pop)); // R11
endmodule

bind pkt_dispatch_ctrl pdc_checker #(.NSIG(NSIG)) u_pdc_checker (
  .clk(clk), .rst(rst), .dsp_valid(dsp_valid), .dsp_kind(dsp_kind),
  .dsp_ready(dsp_ready), .pkt_pop(pkt_pop), .sig_rd_valid(sig_rd_valid),
  .sig_rd_mask(sig_rd_mask), .pkt_dep_conn(pkt_dep_conn),
  .sig_dec_valid(sig_dec_valid), .blocked(blocked), .err(err)
);

// File: tb/pkt_dispatch_ctrl_tb.sv
module pkt_dispatch_ctrl_tb;
  localparam int NSIG = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0]      wake_dly = 8'd4;
  logic            pkt_valid;
  logic [15:0]     pkt_hdr;
  logic [NSIG-1:0] pkt_dep_conn;
  logic            pkt_cpl_conn;
  logic            pkt_pop, dsp_valid, sig_rd_valid, sig_dec_valid, blocked, err;
  logic [1:0]      dsp_kind;
  logic            dsp_ready = 1'b1;
  logic            cpl_done = 1'b0;
  logic [NSIG-1:0] sig_rd_mask;
  logic            sig_rsp_valid = 1'b0;
  logic [2:0]      sig_rsp_slot = '0;
  logic            sig_rsp_nz = 1'b0;

  logic [15:0]     q_hdr  [0:31];
  logic [NSIG-1:0] q_conn [0:31];
  logic            q_cpl  [0:31];
  int q_n = 0;
  int head = 0;

  assign pkt_valid    = head < q_n;
  assign pkt_hdr      = q_hdr[head & 31];
  assign pkt_dep_conn = q_conn[head & 31];
  assign pkt_cpl_conn = q_cpl[head & 31];

  pkt_dispatch_ctrl #(.NSIG(NSIG)) u_dut (
    .clk(clk), .rst(rst), .wake_dly(wake_dly), .pkt_valid(pkt_valid),
    .pkt_hdr(pkt_hdr), .pkt_dep_conn(pkt_dep_conn), .pkt_cpl_conn(pkt_cpl_conn),
    .pkt_pop(pkt_pop), .dsp_valid(dsp_valid), .dsp_kind(dsp_kind),
    .dsp_ready(dsp_ready), .cpl_done(cpl_done), .sig_rd_valid(sig_rd_valid),
    .sig_rd_mask(sig_rd_mask), .sig_rsp_valid(sig_rsp_valid),
    .sig_rsp_slot(sig_rsp_slot), .sig_rsp_nz(sig_rsp_nz),
    .sig_dec_valid(sig_dec_valid), .blocked(blocked), .err(err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rd_cnt = 0;
  int pop_t[$];
  logic [9:0] exp_q[$];
  string      exp_tag[$];
  logic       prev_dv = 1'b0;
  logic [NSIG-1:0] rsp_todo = '0;
  int         rsp_wait = 0;
  int         sig_val [0:NSIG-1];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [9:0] ev, input string tag);
    exp_q.push_back(ev);
    exp_tag.push_back(tag);
  endtask

  task automatic observe(input logic [9:0] ev);
    logic [9:0] e;
    string t;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: actual %h expected none", ev);
    end else begin
      e = exp_q.pop_front();
      t = exp_tag.pop_front();
      if (e != ev) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, ev, e);
      end
    end
  endtask

  task automatic load(input logic [15:0] h, input logic [NSIG-1:0] c, input logic cp);
    q_hdr[q_n & 31] = h;
    q_conn[q_n & 31] = c;
    q_cpl[q_n & 31] = cp;
    q_n++;
  endtask

  task automatic pulse_cpl();
    @(negedge clk) cpl_done = 1'b1;
    @(negedge clk) cpl_done = 1'b0;
  endtask

  // Monitor and signal responder, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      sig_rsp_valid = 1'b0;
      if (rsp_todo != '0) begin
        if (rsp_wait > 0) rsp_wait--;
        else begin
          for (int i = 0; i < NSIG; i++) begin
            if (rsp_todo[i] && !sig_rsp_valid) begin
              sig_rsp_valid = 1'b1;
              sig_rsp_slot  = 3'(i);
              sig_rsp_nz    = (sig_val[i] != 0);
              if (sig_val[i] != 0) sig_val[i]--;
              rsp_todo[i] = 1'b0;
            end
          end
        end
      end
      if (dsp_valid && !prev_dv) observe({2'd1, 6'd0, dsp_kind});
      if (sig_dec_valid) observe({2'd2, 8'd0});
      if (sig_rd_valid) begin
        observe({2'd3, 3'd0, sig_rd_mask});
        rd_cnt++;
        rsp_todo = sig_rd_mask;
        rsp_wait = 6;
      end
      prev_dv = dsp_valid;
      if (pkt_pop) begin
        pop_t.push_back(cyc);
        head++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      q_hdr[i] = '0; q_conn[i] = '0; q_cpl[i] = 1'b0;
    end
    for (int i = 0; i < NSIG; i++) sig_val[i] = 0;
    // R1 R5 R10: compute, vendor, agent back to back
    load(16'h0002, '0, 1'b0);
    load(16'h0000, '0, 1'b0);
    load(16'h0004, '0, 1'b0);
    push_exp({2'd1, 8'd0}, "R1 compute");
    push_exp({2'd1, 8'd1}, "R1 vendor");
    push_exp({2'd1, 8'd2}, "R1 agent");
    push_exp({2'd2, 8'd0}, "R10 agent decrement");
    repeat (4) @(negedge clk);
    chk("R1 reset dsp_valid", dsp_valid, 0);
    chk("R2 reset blocked", blocked, 0);
    chk("R11 reset err", err, 0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk("R1 pops", head, 3);
    chk("R5 wakeup spacing", (pop_t.size() > 1) ? pop_t[1] - pop_t[0] : -1, 6);
    pulse_cpl(); pulse_cpl(); pulse_cpl();

    // R2 R4: ordered packet held behind an incomplete one
    load(16'h0002, '0, 1'b0);
    load(16'h0100, '0, 1'b0);
    push_exp({2'd1, 8'd0}, "R2 compute");
    repeat (40) @(negedge clk);
    chk("R2 blocked", blocked, 1);
    chk("R2 held", head, 4);
    push_exp({2'd1, 8'd1}, "R4 released vendor");
    pulse_cpl();
    repeat (30) @(negedge clk);
    chk("R4 unblocked", blocked, 0);
    chk("R4 released", head, 5);
    pulse_cpl();

    // R3: ordered compute packet goes out, then holds the queue
    load(16'h0102, '0, 1'b0);
    load(16'h0000, '0, 1'b0);
    push_exp({2'd1, 8'd0}, "R3 ordered compute");
    repeat (40) @(negedge clk);
    chk("R3 blocked after forward", blocked, 1);
    chk("R3 next held", head, 6);
    push_exp({2'd1, 8'd1}, "R3 vendor after completion");
    pulse_cpl();
    repeat (30) @(negedge clk);
    chk("R3 released", head, 7);
    pulse_cpl();

    // R12: handshake and completion on the same edge
    load(16'h0002, '0, 1'b0);
    push_exp({2'd1, 8'd0}, "R12 first compute");
    repeat (30) @(negedge clk);
    dsp_ready = 1'b0;
    load(16'h0002, '0, 1'b0);
    push_exp({2'd1, 8'd0}, "R12 second compute");
    repeat (30) @(negedge clk);
    chk("R1 valid held", dsp_valid, 1);
    @(negedge clk); dsp_ready = 1'b1; cpl_done = 1'b1;
    @(negedge clk); cpl_done = 1'b0;
    load(16'h0100, '0, 1'b0);
    repeat (40) @(negedge clk);
    chk("R12 still blocked", blocked, 1);
    chk("R12 held", head, 9);
    push_exp({2'd1, 8'd1}, "R12 vendor after one completion");
    pulse_cpl();
    repeat (30) @(negedge clk);
    chk("R12 released", head, 10);
    pulse_cpl();

    // R6 R7 R8 R9: AND-barrier polling
    wake_dly = 8'd2;
    sig_val[2] = 1;
    load(16'h0003, 5'b01101, 1'b1);
    push_exp({2'd3, 8'h0D}, "R6 full read");
    push_exp({2'd3, 8'h04}, "R7 R8 reread nonzero slot");
    push_exp({2'd2, 8'd0}, "R9 completion decrement");
    repeat (80) @(negedge clk);
    chk("R7 barrier retired", head, 11);
    chk("R8 read count", rd_cnt, 2);
    load(16'h0003, 5'b00000, 1'b0);
    repeat (20) @(negedge clk);
    chk("R7 empty barrier retired", head, 12);
    load(16'h0003, 5'b00010, 1'b0);
    push_exp({2'd3, 8'h02}, "R9 fresh full read");
    repeat (60) @(negedge clk);
    chk("R9 second barrier retired", head, 13);

    // R11: illegal type halts
    load(16'h0001, '0, 1'b0);
    load(16'h0002, '0, 1'b0);
    repeat (40) @(negedge clk);
    chk("R11 err set", err, 1);
    chk("R11 no pop", head, 13);
    chk("R11 no forward", dsp_valid, 0);

    chk("R1 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule